// File: doc/BRIEF.md
# External Interrupt Sense and Flag Unit

This unit watches eight external interrupt pins and turns them into interrupt requests for the vector logic. Each line has a two-bit sense code that selects low-level, falling-edge, rising-edge or, on the upper four lines only, any-change detection. Each line also has an enable bit in a mask register and a sticky flag in a flag register. The pins pass through a two-flop synchronizer. The detector compares the newest synchronized sample with the one before it, and an edge sets the line's flag.

Software reaches the unit through a small register port: two sense-code registers, the mask register and the flag register. Reads are combinational from the address. Writes take effect on the clock edge. A flag is cleared by writing a 1 to its bit or by the vector logic's per-line acknowledge. A line in low-level mode keeps no flag. It requests while its synchronized pin is low, and a combinational wake output follows the raw pin so that a stopped clock can still be woken. The trigger does not depend on the pin's direction, so software can raise an interrupt by driving the pin itself.

Top module: `ext_irq_unit`

## Requirements
- R1: The register map is: address 0 holds the sense codes of lines 0..3 and address 1 holds those of lines 4..7, with line k at bits [2(k mod 4)+1 : 2(k mod 4)]. Address 2 holds the mask (bit k = line k) and address 3 holds the flags (bit k = line k). Read data follows the address combinationally.
- R2: On lines 0..3, code 00 is low level, 01 never triggers, 10 triggers on a falling edge and 11 triggers on a rising edge.
- R3: On lines 4..7, code 00 is low level, 01 triggers on any change, 10 on a falling edge and 11 on a rising edge.
- R4: A line in low-level mode always reads its flag as 0. With its mask bit set, its request equals the inverse of the synchronized pin, and its wake output equals the inverse of the raw pin, combinationally.
- R5: A programmed edge sets the line's flag. An acknowledge on that line clears it on the next clock edge.
- R6: irq_req of a line is 0 whenever its mask bit is 0. With the mask bit set in an edge mode, irq_req equals the flag.
- R7: After reset, all four registers read as zero.
- R8: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R9: A pin change held for at least two clocks is detected. The flag reads 1 after the third rising clock edge following the change, and still reads 0 after the second.
- R10: If an edge and an acknowledge (or a write-one clear) on the same line fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins | input | 8 | External interrupt pins, asynchronous |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_req | output | 8 | Per-line interrupt request to the vector logic |
| irq_ack | input | 8 | Per-line acknowledge from the vector logic |
| wake_lvl | output | 8 | Combinational low-level wake indication |

## Verification
A pin change reaches the second synchronizer flop after two rising edges, and the edge it causes lands in the flag on the third. A level request therefore appears after two edges and an edge flag after three. The bench drives every stimulus on a falling clock edge. Sweep cases wait four full clocks before reading, so that the last register has settled. The dedicated latency case samples just after the second and just after the third edge. The wake output has no register in its path and is checked one time step after the pin is driven. Register writes are read back on the following falling edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ALT  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  typedef enum logic [1:0] {
    ADR_SNS_LO = 2'd0,
    ADR_SNS_HI = 2'd1,
    ADR_MASK   = 2'd2,
    ADR_FLAG   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta_q, cur_q, prv_q;

  // idle-high reset so pulled-up pins show no edge after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      cur_q  <= '1;
      prv_q  <= '1;
    end else begin
      meta_q <= d;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

  assign cur = cur_q;
  assign prv = prv_q;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int TOGGLE_FROM = 4
) (
  input  logic [N_LINES-1:0]   cur,
  input  logic [N_LINES-1:0]   prv,
  input  logic [2*N_LINES-1:0] sense,
  output logic [N_LINES-1:0]   edge_ev,
  output logic [N_LINES-1:0]   lvl_mode
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    localparam bit ALT_OK = (i >= TOGGLE_FROM);
    sense_e code;
    assign code = sense_e'(sense[2*i +: 2]);
    always_comb begin
      edge_ev[i]  = 1'b0;
      lvl_mode[i] = 1'b0;
      unique case (code)
        SNS_LOW:  lvl_mode[i] = 1'b1;
        SNS_ALT:  edge_ev[i]  = ALT_OK & (cur[i] ^ prv[i]);
        SNS_FALL: edge_ev[i]  = prv[i] & ~cur[i];
        SNS_RISE: edge_ev[i]  = ~prv[i] & cur[i];
        default:  edge_ev[i]  = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] edge_ev,
  input  logic [N_LINES-1:0] lvl_mode,
  input  logic [N_LINES-1:0] ack,
  input  logic [N_LINES-1:0] sw_clr,
  output logic [N_LINES-1:0] flag_q
);
  logic [N_LINES-1:0] flag_d;

  // a fresh edge outranks any clear in the same cycle
  assign flag_d = ~lvl_mode & (edge_ev | (flag_q & ~ack & ~sw_clr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int TOGGLE_FROM = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pins,
  input  logic [1:0]         reg_addr,
  input  logic               reg_we,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic [N_LINES-1:0] irq_req,
  input  logic [N_LINES-1:0] irq_ack,
  output logic [N_LINES-1:0] wake_lvl
);
  localparam int SNS_W = 2 * N_LINES;
  localparam int HALF  = SNS_W / 2;

  logic [SNS_W-1:0]   sense_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] cur, prv;
  logic [N_LINES-1:0] edge_ev, lvl_mode, flag_q, sw_clr;
  reg_addr_e          addr;

  assign addr = reg_addr_e'(reg_addr);

  ext_irq_sync #(.W(N_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .cur(cur), .prv(prv)
  );

  ext_irq_detect #(.N_LINES(N_LINES), .TOGGLE_FROM(TOGGLE_FROM)) u_det (
    .cur(cur), .prv(prv), .sense(sense_q), .edge_ev(edge_ev), .lvl_mode(lvl_mode)
  );

  assign sw_clr = (reg_we && addr == ADR_FLAG) ? reg_wdata : '0;

  ext_irq_flags #(.N_LINES(N_LINES)) u_flags (
    .clk(clk), .rst_n(rst_n), .edge_ev(edge_ev), .lvl_mode(lvl_mode),
    .ack(irq_ack), .sw_clr(sw_clr), .flag_q(flag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else if (reg_we) begin
      case (addr)
        ADR_SNS_LO: sense_q[0 +: HALF]    <= reg_wdata[HALF-1:0];
        ADR_SNS_HI: sense_q[HALF +: HALF] <= reg_wdata[HALF-1:0];
        ADR_MASK:   mask_q                <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADR_SNS_LO: reg_rdata = N_LINES'(sense_q[0 +: HALF]);
      ADR_SNS_HI: reg_rdata = N_LINES'(sense_q[HALF +: HALF]);
      ADR_MASK:   reg_rdata = mask_q;
      default:    reg_rdata = flag_q & ~lvl_mode;
    endcase
  end

  assign irq_req  = mask_q & ((lvl_mode & ~cur) | (~lvl_mode & flag_q));
  assign wake_lvl = mask_q & lvl_mode & ~pins;
endmodule

// File: rtl/ext_irq_unit_chk.sv
module ext_irq_unit_chk #(
  parameter int N_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] irq_req,
  input logic [N_LINES-1:0] irq_ack,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] flag_q,
  input logic [N_LINES-1:0] edge_ev,
  input logic [N_LINES-1:0] lvl_mode
);
  // R4: a level-mode line holds no flag one cycle later
  p_level_noflag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & $past(lvl_mode)) == '0));

  // R6: unmasked lines never request
  p_req_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & ~mask_q) == '0));

  // R5: acknowledge without a new edge clears the flag
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & $past(irq_ack & ~edge_ev)) == '0));

  // R10: an edge in an edge mode is always captured, even with an ack
  p_edge_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(edge_ev & ~lvl_mode) & ~flag_q) == '0));
endmodule

bind ext_irq_unit ext_irq_unit_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
  .mask_q(mask_q), .flag_q(flag_q), .edge_ev(edge_ev), .lvl_mode(lvl_mode)
);

// File: tb/test_ext_irq_unit.sv
`timescale 1ns/1ps
module test_ext_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'hFF;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] irq_req;
  logic [7:0] irq_ack = 8'h00;
  logic [7:0] wake_lvl;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_unit i_ext_irq_unit (
    .clk(clk), .rst_n(rst_n), .pins(pins), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_ack(irq_ack), .wake_lvl(wake_lvl)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic bit exp_flag(input int line, input int code, input bit rise);
    case (code)
      2: return !rise;
      3: return rise;
      1: return line >= 4;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R7", "reset register", v, 8'h00);
    end

    // R1: register map read back
    wr(2'd0, 8'hE4); rd(2'd0, v); chk("R1", "sense lo", v, 8'hE4);
    wr(2'd1, 8'h1B); rd(2'd1, v); chk("R1", "sense hi", v, 8'h1B);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);

    // R2/R3/R4: sweep every line, code and edge direction
    wr(2'd2, 8'hFF);
    for (int line = 0; line < 8; line++) begin
      for (int code = 0; code < 4; code++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic [7:0] sv;
          bit rise;
          bit ef;
          bit er;
          rise = (dir == 1);
          pins = 8'hFF;
          pins[line] = rise ? 1'b0 : 1'b1;
          sv = 8'(code << (2 * (line % 4)));
          wr(line < 4 ? 2'd0 : 2'd1, sv);
          cyc(4);
          wr(2'd3, 8'hFF);
          pins[line] = rise ? 1'b1 : 1'b0;
          cyc(4);
          ef = exp_flag(line, code, rise);
          er = (code == 0) ? !rise : ef;
          rd(2'd3, v);
          chk(line < 4 ? "R2" : "R3", $sformatf("flag line%0d code%0d rise%0d", line, code, rise),
              {7'd0, v[line]}, {7'd0, ef});
          chk(code == 0 ? "R4" : "R6", $sformatf("req line%0d code%0d rise%0d", line, code, rise),
              {7'd0, irq_req[line]}, {7'd0, er});
          wr(line < 4 ? 2'd0 : 2'd1, 8'h00);
        end
      end
    end
    pins = 8'hFF;
    cyc(4);

    // R4: wake output follows raw pin with no clock
    pins[2] = 1'b0; #1;
    chk("R4", "wake low", wake_lvl, 8'h04);
    pins[2] = 1'b1; #1;
    chk("R4", "wake high", wake_lvl, 8'h00);
    cyc(4);

    // R9: latency, line 7 rising edge
    wr(2'd1, 8'hC0);
    pins[7] = 1'b0; cyc(4); wr(2'd3, 8'hFF);
    pins[7] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rd(2'd3, v); chk("R9", "flag after two edges", v, 8'h00);
    @(posedge clk); #1;
    rd(2'd3, v); chk("R9", "flag after three edges", v, 8'h80);
    @(negedge clk);

    // R8: write-zero keeps, write-one clears
    wr(2'd3, 8'h00); rd(2'd3, v); chk("R8", "write zero", v, 8'h80);
    wr(2'd3, 8'h80); rd(2'd3, v); chk("R8", "write one", v, 8'h00);

    // R6: mask off blocks request while flag set
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h0C);
    pins[5] = 1'b0; cyc(4); wr(2'd3, 8'hFF);
    pins[5] = 1'b1; cyc(4);
    rd(2'd3, v); chk("R6", "flag under mask off", v, 8'h20);
    chk("R6", "req masked", irq_req, 8'h00);
    wr(2'd2, 8'h20); #1;
    chk("R6", "req unmasked", irq_req, 8'h20);

    // R5: ack clears
    irq_ack = 8'h20; @(negedge clk); irq_ack = 8'h00;
    rd(2'd3, v); chk("R5", "ack clears", v, 8'h00);

    // R10: edge coincident with ack keeps flag (line 4 any change)
    wr(2'd1, 8'h01); wr(2'd2, 8'h10);
    pins[4] = 1'b0; cyc(4);
    rd(2'd3, v); chk("R5", "toggle sets", v, 8'h10);
    pins[4] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    irq_ack = 8'h10; @(negedge clk); irq_ack = 8'h00;
    rd(2'd3, v); chk("R10", "edge beats ack", v, 8'h10);
    irq_ack = 8'h10; @(negedge clk); irq_ack = 8'h00;
    rd(2'd3, v); chk("R5", "lone ack clears", v, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule